// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of cache misses that are still waiting for their block to come back from the next memory level, so that a non-blocking cache can keep serving requests while several misses are in flight. Each entry covers one missing block. It holds the block address, the cache index the block will be written to, a small set of load targets (word offset plus destination register) and a mask of words that stores wrote while the miss was pending.

A miss is offered on the request port for one cycle. One cycle later the block answers with an acknowledge and an entry number, or with a stall that the requester must retry. A miss to a block that already has an entry merges into that entry instead of taking a new one. Fill responses name the entry they complete and may come back in any order. After a fill, the entry's load targets leave one per cycle as word/register pairs together with the cache index. The last one carries a completion pulse with the store write mask, and in that cycle the entry is released.

Top module: `mshr_file`

## Requirements
- R1: After synchronous reset every entry is free and `ack_valid`, `req_stall`, `fwd_valid` and `done_valid` are low.
- R2: A request to a block held by no busy entry, while some entry is free, is answered on the next cycle with `ack_valid`=1, `ack_merge`=0 and `ack_entry` set to the lowest-numbered free entry (entries are numbered 0 to ENTRIES-1).
- R3: A request whose block address equals that of a busy, not yet filled entry is answered with `ack_valid`=1, `ack_merge`=1 and that entry's number, and consumes no new entry.
- R4: A request to an untracked block while all entries are busy is answered with `req_stall`=1 and `ack_valid`=0, and changes no entry.
- R5: A load request that would merge into an entry whose SLOTS target slots are all in use is answered with `req_stall`=1.
- R6: A store request (`req_store`=1) takes no target slot. It sets bit `req_word` of its entry's write mask, so bit i of `done_wmask` stands for word offset i. A store may merge into an entry whose target slots are full.
- R7: When a fill for a busy entry is sampled at clock edge t, that entry's first target appears on `fwd_*` after edge t+1, with further targets on following cycles in the order they were accepted, each carrying the entry's cache index.
- R8: `done_valid` rises together with the last forwarded target, or alone one cycle after the fill if the entry has no targets, carrying the entry number, cache index and write mask; the entry is free for a request sampled at the next edge.
- R9: Fills may arrive in any order; whenever several entries hold returned data, the lowest-numbered one is served in that cycle.
- R10: A request matching an entry whose fill has already arrived is answered with `req_stall`=1.
- R11: A fill naming an entry that is not busy produces no forwarded target and no completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present this cycle |
| req_store | input | 1 | Request is a store (marks write mask, no target) |
| req_blk | input | BLK_W | Block address of the miss |
| req_idx | input | IDX_W | Cache index the block will fill |
| req_word | input | WORD_W | Word offset within the block |
| req_reg | input | REG_W | Destination register for a load |
| ack_valid | output | 1 | Request accepted (registered) |
| ack_merge | output | 1 | Accepted request joined an existing entry |
| ack_entry | output | ENT_W | Entry allocated or merged into |
| req_stall | output | 1 | Request refused, retry later |
| fill_valid | input | 1 | Fill response present |
| fill_entry | input | ENT_W | Entry the fill completes |
| fwd_valid | output | 1 | Forwarded target valid |
| fwd_entry | output | ENT_W | Entry being drained |
| fwd_word | output | WORD_W | Word offset to forward |
| fwd_reg | output | REG_W | Register receiving the word |
| fwd_idx | output | IDX_W | Cache index of the returning block |
| done_valid | output | 1 | Entry finished and released |
| done_entry | output | ENT_W | Entry released |
| done_idx | output | IDX_W | Cache index of the released entry |
| done_wmask | output | 2**WORD_W | Words written by stores during the miss |

## Verification
A wrong busy bit shows at the request port on the very next request: a lost entry gives an early stall or a reused entry number, while a stuck one stalls forever after. Corrupt target slots show as wrong or missing word/register pairs, and a wrong count shows as a completion pulse that comes early or late. Both are visible one to SLOTS cycles after the fill. The scenarios therefore fill the file, overfill the slots, mix stores in and return fills both in reverse order and overlapping, so that each such fault changes an acknowledge, a stall or a forwarded pair within a few cycles.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ALLOC = 2'd1,
    ACT_MERGE = 2'd2,
    ACT_STALL = 2'd3
  } req_act_e;
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry #(
  parameter int BLK_W  = 26,
  parameter int IDX_W  = 6,
  parameter int WORD_W = 3,
  parameter int REG_W  = 5,
  parameter int SLOTS  = 2,
  localparam int WPB    = 1 << WORD_W,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic              merge_en,
  input  logic              req_store,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [WORD_W-1:0] req_word,
  input  logic [REG_W-1:0]  req_reg,
  input  logic              fill_set,
  input  logic              pop_en,
  input  logic              free_en,
  output logic              busy,
  output logic              filled,
  output logic              slots_full,
  output logic [BLK_W-1:0]  blk,
  output logic [IDX_W-1:0]  idx,
  output logic [SLOTS-1:0]  slot_vld,
  output logic [WORD_W-1:0] head_word,
  output logic [REG_W-1:0]  head_reg,
  output logic [WPB-1:0]    wmask
);
  logic [SLOTS-1:0]  vld_q;
  logic [WORD_W-1:0] word_q [SLOTS];
  logic [REG_W-1:0]  reg_q  [SLOTS];
  logic [BLK_W-1:0]  blk_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WPB-1:0]    wmask_q;
  logic              busy_q, filled_q;
  logic [SLOT_W-1:0] free_slot, head_slot, tgt_slot;
  logic              found_free, found_head;
  logic [WPB-1:0]    word_bit;

  assign word_bit = WPB'(1) << req_word;

  always_comb begin
    free_slot  = '0;
    head_slot  = '0;
    found_free = 1'b0;
    found_head = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!vld_q[s] && !found_free) begin
        free_slot  = SLOT_W'(s);
        found_free = 1'b1;
      end
      if (vld_q[s] && !found_head) begin
        head_slot  = SLOT_W'(s);
        found_head = 1'b1;
      end
    end
  end

  assign tgt_slot = alloc_en ? '0 : free_slot;

  // control state, reset
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      filled_q <= 1'b0;
      vld_q    <= '0;
      wmask_q  <= '0;
    end else begin
      if (alloc_en) begin
        busy_q   <= 1'b1;
        filled_q <= 1'b0;
        wmask_q  <= req_store ? word_bit : '0;
        vld_q    <= req_store ? '0 : SLOTS'(1);
      end else if (merge_en) begin
        if (req_store) wmask_q <= wmask_q | word_bit;
        else           vld_q[free_slot] <= 1'b1;
      end
      if (fill_set) filled_q <= 1'b1;
      if (pop_en)   vld_q[head_slot] <= 1'b0;
      if (free_en) begin
        busy_q   <= 1'b0;
        filled_q <= 1'b0;
      end
    end
  end

  // payload storage, written only, no reset
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      blk_q <= req_blk;
      idx_q <= req_idx;
    end
    if ((alloc_en || merge_en) && !req_store) begin
      word_q[tgt_slot] <= req_word;
      reg_q[tgt_slot]  <= req_reg;
    end
  end

  assign busy       = busy_q;
  assign filled     = filled_q;
  assign slots_full = &vld_q;
  assign blk        = blk_q;
  assign idx        = idx_q;
  assign slot_vld   = vld_q;
  assign head_word  = word_q[head_slot];
  assign head_reg   = reg_q[head_slot];
  assign wmask      = wmask_q;
endmodule

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
  parameter int ENTRIES = 4,
  parameter int BLK_W   = 26,
  localparam int ENT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            busy,
  input  logic [ENTRIES-1:0]            filled,
  input  logic [ENTRIES-1:0]            slots_full,
  input  logic [ENTRIES-1:0][BLK_W-1:0] blk_tab,
  input  logic [BLK_W-1:0]              req_blk,
  input  logic                          req_store,
  output logic                          hit,
  output logic [ENT_W-1:0]              hit_entry,
  output logic                          hit_blocked,
  output logic                          free_any,
  output logic [ENT_W-1:0]              free_entry
);
  always_comb begin
    hit         = 1'b0;
    hit_entry   = '0;
    hit_blocked = 1'b0;
    free_any    = 1'b0;
    free_entry  = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (busy[e] && blk_tab[e] == req_blk && !hit) begin
        hit         = 1'b1;
        hit_entry   = ENT_W'(e);
        hit_blocked = filled[e] || (slots_full[e] && !req_store);
      end
      if (!busy[e] && !free_any) begin
        free_any   = 1'b1;
        free_entry = ENT_W'(e);
      end
    end
  end
endmodule

// File: rtl/mshr_drain_sel.sv
module mshr_drain_sel #(
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 2,
  localparam int ENT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            filled,
  input  logic [ENTRIES-1:0][SLOTS-1:0] slot_vld,
  output logic                          sel_any,
  output logic [ENT_W-1:0]              sel_entry,
  output logic                          has_tgt,
  output logic                          last_tgt
);
  logic [SLOTS-1:0] sel_vld;

  always_comb begin
    sel_any   = 1'b0;
    sel_entry = '0;
    sel_vld   = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (filled[e] && !sel_any) begin
        sel_any   = 1'b1;
        sel_entry = ENT_W'(e);
        sel_vld   = slot_vld[e];
      end
    end
    has_tgt  = sel_any && (|sel_vld);
    last_tgt = sel_any && ($countones(sel_vld) <= 1);
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 2,
  parameter int BLK_W   = 26,
  parameter int IDX_W   = 6,
  parameter int WORD_W  = 3,
  parameter int REG_W   = 5,
  localparam int ENT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WPB    = 1 << WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [WORD_W-1:0] req_word,
  input  logic [REG_W-1:0]  req_reg,
  output logic              ack_valid,
  output logic              ack_merge,
  output logic [ENT_W-1:0]  ack_entry,
  output logic              req_stall,
  input  logic              fill_valid,
  input  logic [ENT_W-1:0]  fill_entry,
  output logic              fwd_valid,
  output logic [ENT_W-1:0]  fwd_entry,
  output logic [WORD_W-1:0] fwd_word,
  output logic [REG_W-1:0]  fwd_reg,
  output logic [IDX_W-1:0]  fwd_idx,
  output logic              done_valid,
  output logic [ENT_W-1:0]  done_entry,
  output logic [IDX_W-1:0]  done_idx,
  output logic [WPB-1:0]    done_wmask
);
  import mshr_pkg::*;

  logic [ENTRIES-1:0]            busy, filled, slots_full;
  logic [ENTRIES-1:0][BLK_W-1:0] blk_tab;
  logic [ENTRIES-1:0][SLOTS-1:0] slot_tab;
  logic [ENTRIES-1:0][IDX_W-1:0] idx_tab;
  logic [ENTRIES-1:0][WORD_W-1:0] hword_tab;
  logic [ENTRIES-1:0][REG_W-1:0] hreg_tab;
  logic [ENTRIES-1:0][WPB-1:0]   wmask_tab;

  logic             hit, hit_blocked, free_any;
  logic [ENT_W-1:0] hit_entry, free_entry;
  logic             sel_any, has_tgt, last_tgt;
  logic [ENT_W-1:0] sel_entry;
  req_act_e         act;

  mshr_lookup #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) u_lookup (
    .busy(busy), .filled(filled), .slots_full(slots_full), .blk_tab(blk_tab),
    .req_blk(req_blk), .req_store(req_store),
    .hit(hit), .hit_entry(hit_entry), .hit_blocked(hit_blocked),
    .free_any(free_any), .free_entry(free_entry)
  );

  mshr_drain_sel #(.ENTRIES(ENTRIES), .SLOTS(SLOTS)) u_drain (
    .filled(filled), .slot_vld(slot_tab),
    .sel_any(sel_any), .sel_entry(sel_entry), .has_tgt(has_tgt), .last_tgt(last_tgt)
  );

  always_comb begin
    if (!req_valid)    act = ACT_NONE;
    else if (hit)      act = hit_blocked ? ACT_STALL : ACT_MERGE;
    else if (free_any) act = ACT_ALLOC;
    else               act = ACT_STALL;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic alloc_en, merge_en, fill_set, pop_en, free_en;
    assign alloc_en = (act == ACT_ALLOC) && (free_entry == ENT_W'(e));
    assign merge_en = (act == ACT_MERGE) && (hit_entry == ENT_W'(e));
    assign fill_set = fill_valid && (fill_entry == ENT_W'(e)) && busy[e] && !filled[e];
    assign pop_en   = has_tgt && (sel_entry == ENT_W'(e));
    assign free_en  = last_tgt && (sel_entry == ENT_W'(e));

    mshr_entry #(
      .BLK_W(BLK_W), .IDX_W(IDX_W), .WORD_W(WORD_W), .REG_W(REG_W), .SLOTS(SLOTS)
    ) u_ent (
      .clk(clk), .rst(rst),
      .alloc_en(alloc_en), .merge_en(merge_en), .req_store(req_store),
      .req_blk(req_blk), .req_idx(req_idx), .req_word(req_word), .req_reg(req_reg),
      .fill_set(fill_set), .pop_en(pop_en), .free_en(free_en),
      .busy(busy[e]), .filled(filled[e]), .slots_full(slots_full[e]),
      .blk(blk_tab[e]), .idx(idx_tab[e]), .slot_vld(slot_tab[e]),
      .head_word(hword_tab[e]), .head_reg(hreg_tab[e]), .wmask(wmask_tab[e])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid  <= 1'b0;
      ack_merge  <= 1'b0;
      ack_entry  <= '0;
      req_stall  <= 1'b0;
      fwd_valid  <= 1'b0;
      fwd_entry  <= '0;
      fwd_word   <= '0;
      fwd_reg    <= '0;
      fwd_idx    <= '0;
      done_valid <= 1'b0;
      done_entry <= '0;
      done_idx   <= '0;
      done_wmask <= '0;
    end else begin
      ack_valid <= (act == ACT_ALLOC) || (act == ACT_MERGE);
      ack_merge <= (act == ACT_MERGE);
      req_stall <= (act == ACT_STALL);
      ack_entry <= (act == ACT_MERGE) ? hit_entry : free_entry;
      fwd_valid <= has_tgt;
      if (has_tgt) begin
        fwd_entry <= sel_entry;
        fwd_word  <= hword_tab[sel_entry];
        fwd_reg   <= hreg_tab[sel_entry];
        fwd_idx   <= idx_tab[sel_entry];
      end
      done_valid <= last_tgt;
      if (last_tgt) begin
        done_entry <= sel_entry;
        done_idx   <= idx_tab[sel_entry];
        done_wmask <= wmask_tab[sel_entry];
      end
    end
  end
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int ENTRIES = 4,
  localparam int ENT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               ack_valid,
  input logic               ack_merge,
  input logic [ENT_W-1:0]   ack_entry,
  input logic               req_stall,
  input logic               fwd_valid,
  input logic [ENT_W-1:0]   fwd_entry,
  input logic               done_valid,
  input logic [ENT_W-1:0]   done_entry,
  input logic [ENTRIES-1:0] busy_q
);
  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !ack_valid && !req_stall && !fwd_valid && !done_valid);

  // R2
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (ack_valid != req_stall));

  // R3
  merge_is_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_merge |-> ack_valid);

  // R2
  alloc_marks_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !ack_merge) |-> busy_q[ack_entry]);

  // R8
  retired_stays_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !(fwd_valid && fwd_entry == $past(done_entry))
                   && !(done_valid && done_entry == $past(done_entry)));
endmodule

bind mshr_file mshr_file_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid),
  .ack_valid(ack_valid), .ack_merge(ack_merge), .ack_entry(ack_entry),
  .req_stall(req_stall), .fwd_valid(fwd_valid), .fwd_entry(fwd_entry),
  .done_valid(done_valid), .done_entry(done_entry), .busy_q(busy)
);

// File: tb/mshr_file_test.sv
module mshr_file_test;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 4;
  localparam int SLOTS   = 2;
  localparam int BLK_W   = 26;
  localparam int IDX_W   = 6;
  localparam int WORD_W  = 3;
  localparam int REG_W   = 5;
  localparam int ENT_W   = 2;
  localparam int WPB     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_store = 1'b0;
  logic [BLK_W-1:0]  req_blk = '0;
  logic [IDX_W-1:0]  req_idx = '0;
  logic [WORD_W-1:0] req_word = '0;
  logic [REG_W-1:0]  req_reg = '0;
  logic ack_valid, ack_merge, req_stall;
  logic [ENT_W-1:0] ack_entry;
  logic fill_valid = 1'b0;
  logic [ENT_W-1:0] fill_entry = '0;
  logic fwd_valid, done_valid;
  logic [ENT_W-1:0] fwd_entry, done_entry;
  logic [WORD_W-1:0] fwd_word;
  logic [REG_W-1:0] fwd_reg;
  logic [IDX_W-1:0] fwd_idx, done_idx;
  logic [WPB-1:0] done_wmask;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mshr_file #(.ENTRIES(ENTRIES), .SLOTS(SLOTS), .BLK_W(BLK_W), .IDX_W(IDX_W),
              .WORD_W(WORD_W), .REG_W(REG_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_blk(req_blk), .req_idx(req_idx), .req_word(req_word), .req_reg(req_reg),
    .ack_valid(ack_valid), .ack_merge(ack_merge), .ack_entry(ack_entry),
    .req_stall(req_stall), .fill_valid(fill_valid), .fill_entry(fill_entry),
    .fwd_valid(fwd_valid), .fwd_entry(fwd_entry), .fwd_word(fwd_word),
    .fwd_reg(fwd_reg), .fwd_idx(fwd_idx), .done_valid(done_valid),
    .done_entry(done_entry), .done_idx(done_idx), .done_wmask(done_wmask)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one request, check the answer one cycle later
  task automatic do_req(input bit st, input int blk, input int idx, input int wd,
                        input int rg, input bit exp_ack, input bit exp_merge,
                        input int exp_ent, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_store = st;
    req_blk = BLK_W'(blk); req_idx = IDX_W'(idx);
    req_word = WORD_W'(wd); req_reg = REG_W'(rg);
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
    check({tag, " ack"},   32'(ack_valid), 32'(exp_ack));
    check({tag, " stall"}, 32'(req_stall), 32'(!exp_ack));
    if (exp_ack) begin
      check({tag, " merge"}, 32'(ack_merge), 32'(exp_merge));
      check({tag, " entry"}, 32'(ack_entry), exp_ent);
    end
  endtask

  task automatic send_fill(input int e);
    @(negedge clk);
    fill_valid = 1'b1; fill_entry = ENT_W'(e);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // check the drain outputs at the current sample point
  task automatic look_out(input bit fv, input int ent, input int wd, input int rg,
                          input int idx, input bit dv, input int wm, input string tag);
    check({tag, " fwd_valid"}, 32'(fwd_valid), 32'(fv));
    if (fv) begin
      check({tag, " fwd_entry"}, 32'(fwd_entry), ent);
      check({tag, " fwd_word"},  32'(fwd_word), wd);
      check({tag, " fwd_reg"},   32'(fwd_reg), rg);
      check({tag, " fwd_idx"},   32'(fwd_idx), idx);
    end
    check({tag, " done_valid"}, 32'(done_valid), 32'(dv));
    if (dv) begin
      check({tag, " done_entry"}, 32'(done_entry), ent);
      check({tag, " done_idx"},   32'(done_idx), idx);
      check({tag, " done_wmask"}, 32'(done_wmask), wm);
    end
  endtask

  task automatic expect_out(input bit fv, input int ent, input int wd, input int rg,
                            input int idx, input bit dv, input int wm, input string tag);
    @(negedge clk);
    look_out(fv, ent, wd, rg, idx, dv, wm, tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 ack after reset",   32'(ack_valid), 0);
    check("R1 stall after reset", 32'(req_stall), 0);
    check("R1 fwd after reset",   32'(fwd_valid), 0);
    check("R1 done after reset",  32'(done_valid), 0);
  endtask

  task automatic t_fill_file();
    do_req(0, 'h100, 5,  3, 7, 1, 0, 0, "R1/R2 first alloc");
    do_req(0, 'h200, 9,  2, 3, 1, 0, 1, "R2 alloc B");
    do_req(1, 'h300, 17, 6, 0, 1, 0, 2, "R2/R6 store alloc C");
    do_req(0, 'h400, 33, 0, 4, 1, 0, 3, "R2 alloc D");
    do_req(0, 'h500, 40, 7, 12, 0, 0, 0, "R4 full file");
  endtask

  task automatic t_merge();
    do_req(0, 'h100, 5, 1, 9,  1, 1, 0, "R3 load merge");
    do_req(0, 'h100, 5, 2, 10, 0, 0, 0, "R5 slots full");
    do_req(1, 'h100, 5, 5, 0,  1, 1, 0, "R6 store merge into full");
  endtask

  task automatic t_store_only_fill();
    send_fill(2);
    expect_out(0, 2, 0, 0, 17, 1, 'h40, "R8/R6 no-target entry");
    do_req(0, 'h500, 40, 7, 12, 1, 0, 2, "R8/R2 reuse freed entry");
  endtask

  task automatic t_drain_two();
    send_fill(0);
    expect_out(1, 0, 3, 7, 5, 0, 0,     "R7 first target");
    expect_out(1, 0, 1, 9, 5, 1, 'h20,  "R7/R8 second target");
  endtask

  task automatic t_req_on_filled();
    @(negedge clk);
    fill_valid = 1'b1; fill_entry = 2'd1;
    @(negedge clk);
    fill_valid = 1'b0;
    req_valid = 1'b1; req_store = 1'b0;
    req_blk = BLK_W'('h200); req_idx = 6'd9; req_word = 3'd4; req_reg = 5'd11;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 stall on filled", 32'(req_stall), 1);
    check("R10 no ack on filled", 32'(ack_valid), 0);
    look_out(1, 1, 2, 3, 9, 1, 0, "R10 drain during stall");
    expect_out(0, 0, 0, 0, 0, 0, 0, "R10 nothing extra");
  endtask

  task automatic t_fill_free();
    send_fill(1);
    for (int i = 0; i < 3; i++)
      expect_out(0, 0, 0, 0, 0, 0, 0, "R11 fill to free entry");
  endtask

  task automatic t_reverse_fill();
    @(negedge clk);
    fill_valid = 1'b1; fill_entry = 2'd3;
    @(negedge clk);
    fill_entry = 2'd2;
    @(negedge clk);
    fill_valid = 1'b0;
    look_out(1, 3, 0, 4, 33, 1, 0, "R9 later entry first");
    expect_out(1, 2, 7, 12, 40, 1, 0, "R9 earlier entry second");
  endtask

  task automatic t_priority();
    do_req(0, 'h600, 2, 4, 20, 1, 0, 0, "R2 alloc F");
    do_req(0, 'h700, 3, 6, 22, 1, 0, 1, "R2 alloc G");
    do_req(0, 'h700, 3, 1, 23, 1, 1, 1, "R3 merge G");
    @(negedge clk);
    fill_valid = 1'b1; fill_entry = 2'd1;
    @(negedge clk);
    fill_entry = 2'd0;
    @(negedge clk);
    fill_valid = 1'b0;
    look_out(1, 1, 6, 22, 3, 0, 0, "R9 entry1 starts");
    expect_out(1, 0, 4, 20, 2, 1, 0, "R9 lower entry served first");
    expect_out(1, 1, 1, 23, 3, 1, 0, "R9 entry1 resumes");
    do_req(0, 'h800, 1, 0, 1, 1, 0, 0, "R2 all free again");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill_file();
    t_merge();
    t_store_only_fill();
    t_drain_two();
    t_req_on_filled();
    t_fill_free();
    t_reverse_fill();
    t_priority();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule